// File: doc/BRIEF.md
# ULPI Receive Packet Deframer

This block is the receive half of a link-layer controller that sits beside a ULPI transceiver. While the transceiver drives the shared 8-bit bus, the block examines every cycle. It uses the NXT strobe to sort the bus contents into packet data bytes and receive-command (status) bytes. From the status bytes it follows the receive-active and receive-error events and keeps the most recent line state for other logic. From the data bytes it builds one framed byte stream per USB packet.

When a packet closes, the block emits a one-cycle status word. The status word reports the number of bytes received, the PID nibble, a PID integrity error, whether a receive error was seen, whether the CRC residual matched, and a truncation flag. Downstream protocol logic can use the truncation flag to reject a packet that the transceiver cut short, for example a 10-byte SETUP data stage that delivered only 7, 8 or 9 bytes. A byte count alone would not reveal that. The framed stream holds back one byte, so the end marker lands on the final data byte in the same cycle as the status word.

Top module: `ulpi_rx_deframer`

## Requirements
- R1: Only cycles where DIR has been high for at least one earlier cycle are decoded. A decoded cycle with NXT high is a data byte, and one with NXT low is a receive command. Data bytes seen while no packet is open are dropped, and the rising-DIR turnaround cycle is never treated as data.
- R2: A packet opens when NXT is high during the turnaround cycle, or when a receive command has its RxActive bit (bit 4) set. Both work in high-speed and full-speed pacing, where full speed places several commands between data bytes.
- R3: Every data byte of a packet appears once on the stream, in order. rx_sop marks the first byte, rx_eop marks the last byte, and stat_valid pulses in the same cycle as rx_eop.
- R4: A receive command with bit 4 clear closes the open packet. Any later data bytes or commands are ignored until DIR falls.
- R5: line_state takes bits 1:0 of every receive command, and changes at no other time.
- R6: stat_pid is the low nibble of the first byte. stat_pid_err is set when a first byte exists and its high nibble is not the bitwise inverse of its low nibble.
- R7: For a valid PID whose two low bits are 11 (a data PID), stat_crc_ok is set when a CRC-16 over the bytes after the PID ends at residual 0x800D. The CRC uses polynomial 0x8005, starts from all ones and shifts in each byte LSB first. For any other PID it is clear.
- R8: stat_rx_err is set if any receive command inside the packet carries event code 11 in bits 5:4. Such a command does not close the packet.
- R9: stat_trunc is set when the packet had no bytes, when a data PID had fewer than 3 bytes, when the packet was closed by an all-zero receive command, or when DIR fell while the packet was open.
- R10: stat_count equals the number of data bytes accepted for the packet.
- R11: After synchronous reset, all outputs are zero and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the transceiver |
| rst | input | 1 | Synchronous active-high reset |
| ulpi_dir | input | 1 | Bus direction, high while the transceiver drives |
| ulpi_nxt | input | 1 | Next strobe, high on data cycles |
| ulpi_data | input | 8 | Shared data bus |
| rx_valid | output | 1 | Stream byte valid |
| rx_data | output | 8 | Stream byte |
| rx_sop | output | 1 | First byte of packet |
| rx_eop | output | 1 | Last byte of packet |
| line_state | output | 2 | Most recent line state |
| stat_valid | output | 1 | Status word valid for one cycle |
| stat_count | output | CNT_W | Bytes received in the packet |
| stat_pid | output | 4 | PID low nibble |
| stat_crc_ok | output | 1 | CRC residual matched on a data packet |
| stat_pid_err | output | 1 | PID check nibble mismatch |
| stat_rx_err | output | 1 | Receive error seen during the packet |
| stat_trunc | output | 1 | Packet cut short |

## Verification
The bound checker watches the relationships that must hold in every cycle. A start marker comes only with a valid byte, and an end marker only with a status word. Stream bytes follow a cycle in which the transceiver owned the bus. line_state moves only after a receive command. An empty packet is always flagged truncated, and a CRC pass never accompanies a PID error. The table-driven scenarios show what the assertions cannot: exact byte order, counts, CRC verdicts on intact, corrupted and shortened packets, the three different end conditions, full-speed versus high-speed pacing, and the dropping of bytes after a packet has closed.

// File: rtl/ulpi_rx_pkg.sv
package ulpi_rx_pkg;

  localparam logic [15:0] CRC_SEED     = 16'hFFFF;
  localparam logic [15:0] CRC_POLY     = 16'h8005;
  localparam logic [15:0] CRC_RESIDUAL = 16'h800D;

  typedef enum logic [1:0] {
    EVT_IDLE   = 2'b00,
    EVT_ACTIVE = 2'b01,
    EVT_DISC   = 2'b10,
    EVT_ERROR  = 2'b11
  } rx_evt_e;

  typedef struct packed {
    logic       alt_int;
    logic       id_pin;
    logic [1:0] evt;
    logic [1:0] vbus;
    logic [1:0] ls;
  } rxcmd_t;

  function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] din);
    logic [15:0] r;
    logic        fb;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      fb = din[i] ^ r[15];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic pid_intact(input logic [7:0] p);
    return p[7:4] == ~p[3:0];
  endfunction

  function automatic logic pid_is_data(input logic [7:0] p);
    return pid_intact(p) && (p[1:0] == 2'b11);
  endfunction

endpackage

// File: rtl/ulpi_rx_bus_split.sv
module ulpi_rx_bus_split (
  input  logic clk,
  input  logic rst,
  input  logic ulpi_dir,
  input  logic ulpi_nxt,
  output logic turn_stb,
  output logic data_stb,
  output logic cmd_stb,
  output logic fall_stb
);
  logic dir_q;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= 1'b0;
    else     dir_q <= ulpi_dir;
  end

  always_comb begin
    turn_stb = ulpi_dir && !dir_q;
    data_stb = ulpi_dir && dir_q && ulpi_nxt;
    cmd_stb  = ulpi_dir && dir_q && !ulpi_nxt;
    fall_stb = !ulpi_dir && dir_q;
  end
endmodule

// File: rtl/ulpi_rx_crc16.sv
module ulpi_rx_crc16
  import ulpi_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= CRC_SEED;
    else if (en)    crc <= crc16_step(crc, din);
  end
endmodule

// File: rtl/ulpi_rx_deframer.sv
module ulpi_rx_deframer
  import ulpi_rx_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ulpi_dir,
  input  logic             ulpi_nxt,
  input  logic [7:0]       ulpi_data,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_sop,
  output logic             rx_eop,
  output logic [1:0]       line_state,
  output logic             stat_valid,
  output logic [CNT_W-1:0] stat_count,
  output logic [3:0]       stat_pid,
  output logic             stat_crc_ok,
  output logic             stat_pid_err,
  output logic             stat_rx_err,
  output logic             stat_trunc
);
  localparam logic [CNT_W-1:0] MIN_DATA_LEN = CNT_W'(3);

  logic turn_stb, data_stb, cmd_stb, fall_stb;
  logic in_pkt, closed, have_pend, pend_first, rxerr_q;
  logic [7:0] pend_q, pid_q;
  logic [CNT_W-1:0] count_q;
  logic [15:0] crc_q;
  rxcmd_t cmd;

  logic start_ev, end_cmd, end_fall, end_ev, abrupt, take, crc_en;
  logic trunc_now, crc_ok_now, pid_err_now;

  ulpi_rx_bus_split u_split (
    .clk(clk), .rst(rst), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .turn_stb(turn_stb), .data_stb(data_stb), .cmd_stb(cmd_stb), .fall_stb(fall_stb)
  );

  ulpi_rx_crc16 u_crc (
    .clk(clk), .rst(rst), .clr(start_ev), .en(crc_en), .din(ulpi_data), .crc(crc_q)
  );

  always_comb begin
    cmd         = rxcmd_t'(ulpi_data);
    start_ev    = !in_pkt && !closed && ((turn_stb && ulpi_nxt) || (cmd_stb && cmd.evt[0]));
    end_cmd     = in_pkt && cmd_stb && !cmd.evt[0];
    end_fall    = in_pkt && fall_stb;
    end_ev      = end_cmd || end_fall;
    abrupt      = end_fall || (end_cmd && ulpi_data == 8'h00);
    take        = in_pkt && data_stb;
    crc_en      = take && (count_q != '0);
    pid_err_now = (count_q != '0) && !pid_intact(pid_q);
    crc_ok_now  = (count_q != '0) && pid_is_data(pid_q) && (crc_q == CRC_RESIDUAL);
    trunc_now   = (count_q == '0) || (pid_is_data(pid_q) && count_q < MIN_DATA_LEN) || abrupt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt       <= 1'b0;
      closed       <= 1'b0;
      have_pend    <= 1'b0;
      pend_first   <= 1'b0;
      pend_q       <= '0;
      pid_q        <= '0;
      count_q      <= '0;
      rxerr_q      <= 1'b0;
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_sop       <= 1'b0;
      rx_eop       <= 1'b0;
      line_state   <= '0;
      stat_valid   <= 1'b0;
      stat_count   <= '0;
      stat_pid     <= '0;
      stat_crc_ok  <= 1'b0;
      stat_pid_err <= 1'b0;
      stat_rx_err  <= 1'b0;
      stat_trunc   <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      rx_sop     <= 1'b0;
      rx_eop     <= 1'b0;
      stat_valid <= 1'b0;

      if (cmd_stb) line_state <= cmd.ls;
      if (fall_stb) closed <= 1'b0;

      if (start_ev) begin
        in_pkt    <= 1'b1;
        count_q   <= '0;
        pid_q     <= '0;
        rxerr_q   <= 1'b0;
        have_pend <= 1'b0;
      end

      if (take) begin
        if (have_pend) begin
          rx_valid <= 1'b1;
          rx_data  <= pend_q;
          rx_sop   <= pend_first;
        end
        pend_q     <= ulpi_data;
        pend_first <= (count_q == '0);
        have_pend  <= 1'b1;
        count_q    <= count_q + 1'b1;
        if (count_q == '0) pid_q <= ulpi_data;
      end

      if (in_pkt && cmd_stb && cmd.evt == EVT_ERROR) rxerr_q <= 1'b1;

      if (end_ev) begin
        in_pkt    <= 1'b0;
        closed    <= end_cmd;
        have_pend <= 1'b0;
        if (have_pend) begin
          rx_valid <= 1'b1;
          rx_data  <= pend_q;
          rx_sop   <= pend_first;
          rx_eop   <= 1'b1;
        end
        stat_valid   <= 1'b1;
        stat_count   <= count_q;
        stat_pid     <= pid_q[3:0];
        stat_crc_ok  <= crc_ok_now;
        stat_pid_err <= pid_err_now;
        stat_rx_err  <= rxerr_q;
        stat_trunc   <= trunc_now;
      end
    end
  end
endmodule

// File: rtl/ulpi_rx_deframer_chk.sv
module ulpi_rx_deframer_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             ulpi_dir,
  input logic             ulpi_nxt,
  input logic             rx_valid,
  input logic             rx_sop,
  input logic             rx_eop,
  input logic [1:0]       line_state,
  input logic             stat_valid,
  input logic [CNT_W-1:0] stat_count,
  input logic             stat_crc_ok,
  input logic             stat_pid_err,
  input logic             stat_trunc
);
  assert_sop_has_byte_R3: assert property (@(posedge clk) disable iff (rst)
    rx_sop |-> rx_valid);

  assert_eop_with_status_R3: assert property (@(posedge clk) disable iff (rst)
    rx_eop |-> (rx_valid && stat_valid));

  assert_byte_after_bus_owned_R1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(ulpi_dir) || $past(ulpi_dir, 2)));

  assert_linestate_from_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_state) |-> ($past(ulpi_dir && !ulpi_nxt) && $past(ulpi_dir, 2)));

  assert_empty_is_trunc_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_count == '0) |-> stat_trunc);

  assert_crc_excludes_pid_err_R7: assert property (@(posedge clk) disable iff (rst)
    stat_crc_ok |-> !stat_pid_err);
endmodule

bind ulpi_rx_deframer ulpi_rx_deframer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
  .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .line_state(line_state),
  .stat_valid(stat_valid), .stat_count(stat_count), .stat_crc_ok(stat_crc_ok),
  .stat_pid_err(stat_pid_err), .stat_trunc(stat_trunc)
);

// File: tb/ulpi_rx_deframer_tb.sv
module ulpi_rx_deframer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 11;

  typedef struct packed {
    logic       hs;
    logic [7:0] pid;
    logic [7:0] plen;
    logic [7:0] nsent;
    logic [1:0] endm;
    logic       rxerr;
    logic       extra;
    logic       flip;
  } scen_t;

  localparam int NSC = 12;
  localparam scen_t SC [NSC] = '{
    '{1'b1, 8'hC3, 8'd8, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'hC3, 8'd8, 8'd9, 2'd1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h4B, 8'd8, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'hC3, 8'd8, 8'd7, 2'd2, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h69, 8'd2, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'hC4, 8'd3, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'hC3, 8'd8, 8'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h4B, 8'd8, 8'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 8'hD2, 8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'hC3, 8'd0, 8'd0, 2'd0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'hC3, 8'd4, 8'd0, 2'd2, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h4B, 8'd8, 8'd0, 2'd0, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ulpi_dir = 1'b0, ulpi_nxt = 1'b0;
  logic [7:0] ulpi_data = '0;
  logic rx_valid, rx_sop, rx_eop, stat_valid, stat_crc_ok, stat_pid_err, stat_rx_err, stat_trunc;
  logic [7:0] rx_data;
  logic [1:0] line_state;
  logic [CNT_W-1:0] stat_count;
  logic [3:0] stat_pid;

  int n_chk = 0, n_err = 0;
  logic [7:0] got_d [64];
  logic got_s [64];
  logic got_e [64];
  int n_got = 0, n_stat = 0;
  int s_cnt; logic [3:0] s_pid; logic s_crc, s_perr, s_rxe, s_tr;
  logic [7:0] pkt [40];

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_rx_deframer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_data(ulpi_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .line_state(line_state), .stat_valid(stat_valid), .stat_count(stat_count),
    .stat_pid(stat_pid), .stat_crc_ok(stat_crc_ok), .stat_pid_err(stat_pid_err),
    .stat_rx_err(stat_rx_err), .stat_trunc(stat_trunc)
  );

  always @(posedge clk) begin
    #1;
    if (rx_valid && n_got < 64) begin
      got_d[n_got] = rx_data; got_s[n_got] = rx_sop; got_e[n_got] = rx_eop;
      n_got++;
    end
    if (stat_valid) begin
      n_stat++;
      s_cnt = int'(stat_count); s_pid = stat_pid; s_crc = stat_crc_ok;
      s_perr = stat_pid_err; s_rxe = stat_rx_err; s_tr = stat_trunc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic d, input logic n, input logic [7:0] v);
    @(negedge clk);
    ulpi_dir = d; ulpi_nxt = n; ulpi_data = v;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, 8'h00);
  endtask

  function automatic logic [15:0] ref_crc(input int first, input int last);
    logic [15:0] c = 16'hFFFF;
    for (int i = first; i <= last; i++)
      for (int b = 0; b < 8; b++)
        if ((c[0] ^ pkt[i][b]) == 1'b1) c = (c >> 1) ^ 16'hA001;
        else c = c >> 1;
    return c;
  endfunction

  function automatic logic pid_ok_ref(input logic [7:0] p);
    return (p[7:4] ^ p[3:0]) == 4'hF;
  endfunction

  task automatic run_scen(input int idx);
    scen_t sc = SC[idx];
    int total, s;
    logic is_data, e_crc, e_trunc, e_perr;
    logic [15:0] c;
    pkt[0] = sc.pid;
    for (int k = 0; k < int'(sc.plen); k++) pkt[k+1] = 8'((k*29 + idx*7 + 1) & 255);
    total = int'(sc.plen) + 1;
    is_data = pid_ok_ref(sc.pid) && sc.pid[1:0] == 2'b11;
    if (is_data) begin
      c = ~ref_crc(1, total - 1);
      pkt[total] = c[7:0]; pkt[total+1] = c[15:8];
      total += 2;
    end
    if (sc.flip) pkt[2] = pkt[2] ^ 8'h10;
    s = (sc.nsent == 0) ? total : int'(sc.nsent);
    n_got = 0; n_stat = 0;

    cyc(1'b1, sc.hs, 8'h00);
    if (!sc.hs) cyc(1'b1, 1'b0, 8'h11);
    for (int i = 0; i < s; i++) begin
      if (sc.rxerr && i == 3) cyc(1'b1, 1'b0, 8'h31);
      cyc(1'b1, 1'b1, pkt[i]);
      if (!sc.hs) for (int r = 0; r < 3; r++) cyc(1'b1, 1'b0, 8'h11);
    end
    if (sc.endm == 2'd0) cyc(1'b1, 1'b0, 8'h01);
    if (sc.endm == 2'd1) cyc(1'b1, 1'b0, 8'h00);
    if (sc.extra) begin
      cyc(1'b1, 1'b1, 8'hAA); cyc(1'b1, 1'b1, 8'hAB); cyc(1'b1, 1'b0, 8'h11); cyc(1'b1, 1'b1, 8'hAC);
    end
    idle(4);

    e_perr  = (s != 0) && !pid_ok_ref(sc.pid);
    e_crc   = is_data && (s > 0) && (ref_crc(1, s - 1) == 16'hB001);
    e_trunc = (s == 0) || (is_data && s < 3) || (sc.endm != 2'd0);

    check($sformatf("R3 status count scen %0d", idx), n_stat, 1);
    check($sformatf("R10 byte count scen %0d", idx), s_cnt, s);
    check($sformatf("R6 pid scen %0d", idx), s_pid, sc.pid[3:0]);
    check($sformatf("R6 pid error scen %0d", idx), s_perr, e_perr);
    check($sformatf("R7 crc scen %0d", idx), s_crc, e_crc);
    check($sformatf("R8 rx error scen %0d", idx), s_rxe, sc.rxerr);
    check($sformatf("R9 trunc scen %0d", idx), s_tr, e_trunc);
    check($sformatf("R3 stream length scen %0d", idx), n_got, s);
    for (int i = 0; i < s && i < n_got; i++) begin
      check($sformatf("R3 byte %0d scen %0d", i, idx), got_d[i], pkt[i]);
      check($sformatf("R3 sop %0d scen %0d", i, idx), got_s[i], i == 0);
      check($sformatf("R3 eop %0d scen %0d", i, idx), got_e[i], i == s - 1);
    end
    if (sc.extra) check("R4 bytes after close ignored", n_got, s);
    if (!sc.hs) check($sformatf("R2 full-speed start scen %0d", idx), n_got, s);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset rx_valid", rx_valid, 0);
    check("R11 reset stat_valid", stat_valid, 0);
    check("R11 reset line_state", line_state, 0);
    check("R11 reset stat_count", int'(stat_count), 0);

    for (int i = 0; i < NSC; i++) run_scen(i);

    // R5: line state follows commands only
    cyc(1'b1, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 8'h02);
    @(negedge clk);
    check("R5 line state from command", line_state, 2);
    cyc(1'b1, 1'b1, 8'h03);
    cyc(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    check("R5 data byte leaves line state", line_state, 2);

    // R1: data with no open packet is dropped, turnaround not data
    n_got = 0; n_stat = 0;
    cyc(1'b1, 1'b0, 8'h77);
    cyc(1'b1, 1'b0, 8'h01);
    cyc(1'b1, 1'b1, 8'h55);
    cyc(1'b1, 1'b1, 8'h56);
    idle(4);
    check("R1 idle data dropped", n_got, 0);
    check("R1 no status without packet", n_stat, 0);

    // R9: empty packet closed by all-zero command
    n_got = 0; n_stat = 0;
    cyc(1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 8'h00);
    idle(4);
    check("R9 empty packet status", n_stat, 1);
    check("R9 empty packet count", s_cnt, 0);
    check("R9 empty packet trunc", s_tr, 1);
    check("R3 empty packet no bytes", n_got, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule